// File: doc/BRIEF.md
# ATM Cell Receive Port (PHY Side of the Transmit Bus)

This block sits on the PHY side of a byte-wide cell bus. An upstream ATM-layer master drives bytes, a start-of-cell marker and an active-low enable into it, and writes cells into the device. The block frames 53-byte cells from the start-of-cell marker. It keeps only complete cells in a small byte FIFO, and a consumer inside the device drains that FIFO one byte at a time.

The port tells the master when it can take one whole cell through a cell-available flag. That flag comes with its own output-enable, so a pad can tri-state it. In single-PHY mode the flag is always driven. In multi-PHY mode the port answers to one active-low address line. The flag is driven in the cycle after that line was low. A burst is taken only when the line was low in the cycle the enable went active. That selection then holds for the whole burst.

Top module: `uprx_port`

## Requirements
- R1: While `rst` is high, `cav_oe` is 0 and `rd_valid` is 0.
- R2: `cav` is 1 only when the FIFO has room for one complete 53-byte cell beyond the committed cells and any cell in progress. With the default 128-byte FIFO, two stored cells make `cav` 0, and draining them makes it 1 again.
- R3: With `mode_multi` = 0, `cav_oe` is 1 on every cycle after the first clock edge following reset release.
- R4: With `mode_multi` = 1, `cav_oe` in a cycle equals the inverse of `bus_addr_n` in the previous cycle.
- R5: With `mode_multi` = 0, every byte presented with `bus_en_n` = 0 is accepted.
- R6: With `mode_multi` = 1, a burst starts in the cycle where `bus_en_n` goes from 1 to 0. The burst is accepted only if `bus_addr_n` is 0 in that cycle. Otherwise every byte of the burst is ignored.
- R7: An accepted byte with `bus_soc` = 1 starts a cell. The cell becomes readable after its 53rd accepted byte. Accepted bytes that arrive while no cell is open are dropped.
- R8: A new start-of-cell inside an open cell discards the partial cell and opens a new one. Only the new cell is stored.
- R9: In multi-PHY mode, once a burst is accepted, changes on `bus_addr_n` do not stop it until `bus_en_n` returns to 1.
- R10: A start-of-cell that arrives when there is no room for a whole cell is ignored, together with the rest of that cell. Stored cells are left intact.
- R11: `rd_valid` is 1 while committed bytes remain. `rd_en` pops one byte, and the bytes come out in arrival order. `rd_first` is 1 on the first byte of each cell.
- R12: Cycles with `bus_en_n` = 1 neither write nor advance the byte count. A cell split by idle cycles is still framed from its 53 accepted bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_multi | input | 1 | 0 = single-PHY, 1 = multi-PHY |
| bus_data | input | 8 | Cell byte from the master |
| bus_soc | input | 1 | Start-of-cell marker on the current byte |
| bus_en_n | input | 1 | Active-low byte enable |
| bus_addr_n | input | 1 | Active-low device select (multi-PHY) |
| cav | output | 1 | Cell-available flag |
| cav_oe | output | 1 | Output-enable for `cav` |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_valid | output | 1 | A committed byte is at the FIFO head |
| rd_data | output | 8 | Byte at the FIFO head |
| rd_first | output | 1 | The head byte is the first of a cell |

## Verification
Inputs change at falling edges, and each one is taken at the next rising edge. `cav_oe` follows the address line one rising edge later, so the bench sets the address and reads `cav_oe` at the next falling edge. A cell is committed at the rising edge that takes its 53rd byte, so `rd_valid` and `cav` are read some idle cycles after the last byte. A pop takes effect at the rising edge after `rd_en` is set, so the bench compares each head byte at a falling edge before it pops that byte.

// File: rtl/uprx_pkg.sv
package uprx_pkg;

    localparam int CELL_BYTES = 53;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_MULTI  = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic wr;
        logic commit;
        logic drop;
    } frame_ctl_t;

    function automatic logic burst_start(input logic en_n, input logic en_prev_n);
        return !en_n && en_prev_n;
    endfunction

endpackage

// File: rtl/uprx_select.sv
module uprx_select
    import uprx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  port_mode_e mode,
    input  logic       en_n,
    input  logic       addr_n,
    output logic       accept
);
    logic en_prev_n;
    logic sel_q;
    logic start;
    logic selected;

    always_comb begin
        start = burst_start(en_n, en_prev_n);
        if (mode == MODE_MULTI)
            selected = start ? !addr_n : sel_q;
        else
            selected = 1'b1;
        accept = !en_n && selected;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev_n <= 1'b1;
            sel_q     <= 1'b0;
        end else begin
            en_prev_n <= en_n;
            if (start)
                sel_q <= !addr_n;
            else if (en_n)
                sel_q <= 1'b0;
        end
    end

    // R9: an accepted multi-PHY burst keeps going while enable stays low
    assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_MULTI) && $stable(mode) && !en_n && !$past(en_n) && $past(accept)
        |-> accept);

endmodule

// File: rtl/uprx_framer.sv
module uprx_framer
    import uprx_pkg::*;
#(
    parameter int CELL  = CELL_BYTES,
    localparam int CNT_W = $clog2(CELL + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       soc,
    input  logic       room_ok,
    output frame_ctl_t ctl,
    output logic       in_cell
);
    logic [CNT_W-1:0] cnt, cnt_nxt;

    always_comb begin
        ctl     = '0;
        cnt_nxt = cnt;
        if (accept) begin
            if (soc) begin
                ctl.drop = (cnt != '0);
                if (room_ok) begin
                    ctl.wr  = 1'b1;
                    cnt_nxt = CNT_W'(1);
                end else begin
                    cnt_nxt = '0;
                end
            end else if (cnt != '0) begin
                ctl.wr = 1'b1;
                if (cnt == CNT_W'(CELL - 1)) begin
                    ctl.commit = 1'b1;
                    cnt_nxt    = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
        end
        in_cell = (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

endmodule

// File: rtl/uprx_cellfifo.sv
module uprx_cellfifo
    import uprx_pkg::*;
#(
    parameter int CELL      = CELL_BYTES,
    parameter int FIFO_BYTES = 128,
    localparam int AW    = $clog2(FIFO_BYTES),
    localparam int PTR_W = AW + 1,
    localparam int CNT_W = $clog2(CELL + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_ctl_t ctl,
    input  logic [7:0] wr_data,
    input  logic       in_cell,
    input  logic       rd_en,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_first,
    output logic       room_ok,
    output logic       cav
);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(FIFO_BYTES);
    localparam logic [PTR_W-1:0] ONE_P   = PTR_W'(CELL);
    localparam logic [PTR_W-1:0] TWO_P   = PTR_W'(2 * CELL);

    logic [7:0]       mem [FIFO_BYTES];
    logic [PTR_W-1:0] wr_ptr, cmt_ptr, rd_ptr;
    logic [PTR_W-1:0] waddr, used_c, free_c;
    logic [CNT_W-1:0] rd_idx;
    logic             pop;

    always_comb begin
        waddr    = ctl.drop ? cmt_ptr : wr_ptr;
        used_c   = cmt_ptr - rd_ptr;
        free_c   = DEPTH_P - used_c;
        room_ok  = free_c >= ONE_P;
        cav      = free_c >= (in_cell ? TWO_P : ONE_P);
        rd_valid = (used_c != '0);
        pop      = rd_en && rd_valid;
        rd_data  = mem[rd_ptr[AW-1:0]];
        rd_first = (rd_idx == '0);
    end

    always_ff @(posedge clk) begin
        if (ctl.wr)
            mem[waddr[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            cmt_ptr <= '0;
            rd_ptr  <= '0;
            rd_idx  <= '0;
        end else begin
            if (ctl.wr)        wr_ptr <= waddr + PTR_W'(1);
            else if (ctl.drop) wr_ptr <= cmt_ptr;
            if (ctl.commit)    cmt_ptr <= wr_ptr + PTR_W'(1);
            if (pop) begin
                rd_ptr <= rd_ptr + PTR_W'(1);
                rd_idx <= (rd_idx == CNT_W'(CELL - 1)) ? '0 : rd_idx + CNT_W'(1);
            end
        end
    end

    // R7: a cell is committed only on its 53rd byte
    assert_commit_len_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.commit |-> (wr_ptr - cmt_ptr) == PTR_W'(CELL - 1));

    // R10: no write ever lands on unread data
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.wr |-> (waddr - rd_ptr) < DEPTH_P);

endmodule

// File: rtl/uprx_port.sv
module uprx_port
    import uprx_pkg::*;
#(
    parameter int FIFO_BYTES = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_multi,
    input  logic [7:0] bus_data,
    input  logic       bus_soc,
    input  logic       bus_en_n,
    input  logic       bus_addr_n,
    output logic       cav,
    output logic       cav_oe,
    input  logic       rd_en,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_first
);
    port_mode_e mode;
    logic       accept;
    logic       room_ok;
    logic       in_cell;
    frame_ctl_t ctl;

    assign mode = mode_multi ? MODE_MULTI : MODE_SINGLE;

    uprx_select u_sel (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .en_n   (bus_en_n),
        .addr_n (bus_addr_n),
        .accept (accept)
    );

    uprx_framer #(.CELL(CELL_BYTES)) u_frm (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .soc     (bus_soc),
        .room_ok (room_ok),
        .ctl     (ctl),
        .in_cell (in_cell)
    );

    uprx_cellfifo #(.CELL(CELL_BYTES), .FIFO_BYTES(FIFO_BYTES)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .wr_data  (bus_data),
        .in_cell  (in_cell),
        .rd_en    (rd_en),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_first (rd_first),
        .room_ok  (room_ok),
        .cav      (cav)
    );

    always_ff @(posedge clk) begin
        if (rst)                    cav_oe <= 1'b0;
        else if (mode == MODE_MULTI) cav_oe <= !bus_addr_n;
        else                        cav_oe <= 1'b1;
    end

    // R4: in multi-PHY mode the flag is driven one cycle after a poll
    assert_poll_oe_R4: assert property (@(posedge clk) disable iff (rst)
        mode_multi && $past(mode_multi) && !$past(rst) |-> cav_oe == !$past(bus_addr_n));

    // R12: a cycle that is not accepted never writes the FIFO
    assert_idle_nowrite_R12: assert property (@(posedge clk) disable iff (rst)
        !accept |-> !ctl.wr);

    // R2: a start-of-cell seen while the flag was up always opens a cell
    assert_cav_room_R2: assert property (@(posedge clk) disable iff (rst)
        cav && accept && bus_soc |=> in_cell);

endmodule

// File: tb/sim_uprx_port.sv
module sim_uprx_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_multi = 1'b0;
    logic [7:0] bus_data = '0;
    logic       bus_soc = 1'b0;
    logic       bus_en_n = 1'b1;
    logic       bus_addr_n = 1'b1;
    logic       cav, cav_oe;
    logic       rd_en = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_first;

    int checks = 0;
    int failures = 0;

    localparam int CELL = 53;

    // {multi[15], addr_low[14], toggle[13], gap[12], restart[11:6], unused[5:2], cells[1:0]}
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 6'd0,  4'd0, 2'd1},
        {1'b0, 1'b0, 1'b0, 1'b1, 6'd0,  4'd0, 2'd1},
        {1'b0, 1'b0, 1'b0, 1'b0, 6'd20, 4'd0, 2'd1},
        {1'b1, 1'b1, 1'b0, 1'b0, 6'd0,  4'd0, 2'd1},
        {1'b1, 1'b0, 1'b0, 1'b0, 6'd0,  4'd0, 2'd0},
        {1'b1, 1'b1, 1'b1, 1'b0, 6'd0,  4'd0, 2'd1},
        {1'b1, 1'b1, 1'b0, 1'b1, 6'd0,  4'd0, 2'd1},
        {1'b1, 1'b1, 1'b0, 1'b0, 6'd10, 4'd0, 2'd1}
    };

    uprx_port u0 (
        .clk(clk), .rst(rst), .mode_multi(mode_multi), .bus_data(bus_data),
        .bus_soc(bus_soc), .bus_en_n(bus_en_n), .bus_addr_n(bus_addr_n),
        .cav(cav), .cav_oe(cav_oe), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_first(rd_first)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_cell(input logic [7:0] seed, input bit addr_lo, input bit tog,
                             input bit gap, input int restart);
        bus_addr_n = !addr_lo;
        for (int k = 0; k < restart; k++) begin
            bus_en_n = 1'b0; bus_soc = (k == 0); bus_data = 8'hEE;
            @(negedge clk);
        end
        for (int k = 0; k < CELL; k++) begin
            if (gap && k == 20) begin
                bus_en_n = 1'b1; bus_addr_n = 1'b1; bus_soc = 1'b0;
                @(negedge clk); @(negedge clk);
                bus_addr_n = !addr_lo;
            end
            if (tog && k == 5) bus_addr_n = 1'b1;
            bus_en_n = 1'b0; bus_soc = (k == 0); bus_data = seed + 8'(k);
            @(negedge clk);
        end
        bus_en_n = 1'b1; bus_soc = 1'b0; bus_addr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // R11: pops everything, checks order, content and first-byte flag
    task automatic drain(input string req, input int cells, input logic [7:0] sa, input logic [7:0] sb);
        int got = 0;
        int bad = 0;
        for (int guard = 0; guard < 300; guard++) begin
            if (!rd_valid) break;
            if (got < cells * CELL) begin
                if (rd_data != ((got / CELL == 0) ? sa : sb) + 8'(got % CELL)) bad++;
                if (rd_first != ((got % CELL) == 0)) bad++;
            end
            got++;
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        rd_en = 1'b0;
        check({req, " byte count"}, got, cells * CELL);
        check({req, " R11 content"}, bad, 0);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 cav_oe in reset", cav_oe, 0);
        check("R1 rd_valid in reset", rd_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        // R3 single-PHY drives flag every cycle
        for (int i = 0; i < 4; i++) begin
            check("R3 cav_oe single", cav_oe, 1);
            @(negedge clk);
        end
        check("R2 cav empty", cav, 1);

        // R4 poll timing
        mode_multi = 1'b1; bus_addr_n = 1'b0;
        @(negedge clk);
        check("R4 cav_oe after poll", cav_oe, 1);
        bus_addr_n = 1'b1;
        @(negedge clk);
        check("R4 cav_oe after release", cav_oe, 0);
        @(negedge clk);
        check("R4 cav_oe idle", cav_oe, 0);

        // table walk: R5 R6 R8 R9 R12
        for (int i = 0; i < 8; i++) begin
            logic [7:0] seed;
            seed = 8'(16 * (i + 1));
            mode_multi = VEC[i][15];
            @(negedge clk);
            send_cell(seed, VEC[i][14], VEC[i][13], VEC[i][12], int'(VEC[i][11:6]));
            check($sformatf("R5/R6/R8/R9/R12 vec%0d rd_valid", i), rd_valid, (VEC[i][1:0] != 0) ? 1 : 0);
            drain($sformatf("R6/R8 vec%0d", i), int'(VEC[i][1:0]), seed, seed);
            check($sformatf("R2 vec%0d cav after drain", i), cav, 1);
        end

        // R2 and R10: fill, overfill, drain
        mode_multi = 1'b0;
        @(negedge clk);
        send_cell(8'hA0, 1'b0, 1'b0, 1'b0, 0);
        check("R2 cav one cell stored", cav, 1);
        send_cell(8'h30, 1'b0, 1'b0, 1'b0, 0);
        check("R2 cav two cells stored", cav, 0);
        send_cell(8'h55, 1'b0, 1'b0, 1'b0, 0);
        check("R10 cav still low", cav, 0);
        drain("R10 overfill", 2, 8'hA0, 8'h30);
        check("R2 cav after drain", cav, 1);

        // R7: bytes with no open cell are dropped
        for (int k = 0; k < 30; k++) begin
            bus_en_n = 1'b0; bus_soc = 1'b0; bus_data = 8'(k);
            @(negedge clk);
        end
        bus_en_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 stray bytes dropped", rd_valid, 0);
        send_cell(8'h07, 1'b0, 1'b0, 1'b0, 0);
        drain("R7 cell after stray", 1, 8'h07, 8'h07);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule